// File: doc/BRIEF.md
# Streaming Multi-Pattern Byte Matcher

This block scans a stream of bytes, one per valid cycle, against a fixed set of patterns chosen at elaboration time. Each pattern is a short sequence of elements. An element can be a literal byte, a choice between two bytes, or a wildcard that accepts any byte. Adjacent elements can be marked as one optional group, which the pattern may either contain or skip. The set of patterns acts as one large alternation. A match can begin at any byte offset. Partial matches may overlap freely, and several patterns can complete on the same byte.

The matcher is a nondeterministic automaton built directly in hardware, with one flip-flop per pattern position. Each flip-flop records that the pattern prefix up to and including its position ended on the previous byte. A start-of-stream flag on a byte throws away every partial match left from earlier bytes. The outputs are one registered bit per pattern and a registered combined flag. The default set holds five patterns: `a(b|c)?`, `GE?T`, `x.z`, `ab(cd)?` and `aba`.

Top module: `nfa_matcher`

## Requirements
- R1: Synchronous reset (`rst` high) clears every partial match and forces `hit_vec` and `hit_any` to 0. A prefix fed in before reset does not complete after reset.
- R2: A literal element compares the incoming byte with its code and passes only when the preceding element has completed. Elements chain in order, so `GET` raises `hit_vec[1]` after `T`.
- R3: A wildcard element accepts any byte value. Pattern 2 (`x.z`) completes on `z` whatever byte sits between `x` and `z`.
- R4: An optional group can be skipped. Pattern 0 completes on `a`, `ab` and `ac`. Pattern 1 completes on `GT` and `GET`. Pattern 3 completes on `ab` and `abcd` but not on `abc`.
- R5: Matching is unanchored: a pattern can start at any byte offset after the start of the stream.
- R6: Overlapping occurrences are each reported. On `ababa`, `hit_vec[4]` pulses after the third byte and again after the fifth.
- R7: When several patterns complete on the same byte, all of their bits rise together and `hit_any` shows a single 1 in that cycle.
- R8: A cycle with `in_valid` low does not advance any partial match, and it leaves both outputs at 0 in the following cycle.
- R9: A valid byte with `in_sop` high discards every partial match from earlier bytes. That byte can still begin a new match, and can complete a one-byte pattern.
- R10: Outputs are registered. A completion shows in the clock cycle after its byte and lasts one cycle.
- R11: `hit_any` equals the OR of all `hit_vec` bits in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_sop | input | 1 | With `in_valid`: this byte starts a new stream |
| in_byte | input | 8 | Stream byte |
| hit_any | output | 1 | Some pattern completed on the previous valid byte |
| hit_vec | output | NUM_PATS | Per-pattern completion flags |

## Verification
The start-of-stream discard can land on the same byte that completes a pattern. For example, `in_sop` on the `T` after a pending `G` must suppress pattern 1, while on an `a` it must still report pattern 0. Several patterns can also finish together, as `ab` ending patterns 0 and 3, or `aba` ending 0 and 4. Directed sequences force both collisions. Random runs over a small alphabet with scattered `in_sop` and idle cycles produce them many more times. A bench model compares the recent bytes since the last start against each pattern's expanded strings, and every cycle checks the full vector and the combined flag against that model.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

    localparam int MAX_PATS = 8;
    localparam int MAX_LEN  = 16;

    // One pattern position: two acceptable codes (equal for a plain literal),
    // wildcard, optional-group membership and group head marker.
    typedef struct packed {
        logic       used;
        logic       head;
        logic       opt;
        logic       wild;
        logic [7:0] alt;
        logic [7:0] chr;
    } elem_t;

    typedef elem_t [MAX_LEN-1:0]  pat_row_t;
    typedef pat_row_t [MAX_PATS-1:0] pat_set_t;

    function automatic elem_t mk(input logic [7:0] c, input logic [7:0] a,
                                 input logic w, input logic o, input logic h);
        elem_t e;
        e.used = 1'b1;
        e.head = h;
        e.opt  = o;
        e.wild = w;
        e.alt  = a;
        e.chr  = c;
        return e;
    endfunction

    function automatic elem_t lit(input logic [7:0] c);
        return mk(c, c, 1'b0, 1'b0, 1'b0);
    endfunction

    function automatic int row_len(input pat_row_t r);
        int n = 0;
        while (n < MAX_LEN && r[n].used) n++;
        return n;
    endfunction

    function automatic int grp_head(input pat_row_t r, input int j);
        int h = j;
        while (h > 0 && !r[h].head) h--;
        return h;
    endfunction

    function automatic bit opt_end(input pat_row_t r, input int j);
        if (!r[j].opt) return 1'b0;
        if (j == MAX_LEN-1) return 1'b1;
        return !r[j+1].used || !r[j+1].opt || r[j+1].head;
    endfunction

    function automatic pat_set_t default_set();
        pat_set_t s = '0;
        s[0][0] = lit("a");
        s[0][1] = mk("b", "c", 1'b0, 1'b1, 1'b1);
        s[1][0] = lit("G");
        s[1][1] = mk("E", "E", 1'b0, 1'b1, 1'b1);
        s[1][2] = lit("T");
        s[2][0] = lit("x");
        s[2][1] = mk(8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
        s[2][2] = lit("z");
        s[3][0] = lit("a");
        s[3][1] = lit("b");
        s[3][2] = mk("c", "c", 1'b0, 1'b1, 1'b1);
        s[3][3] = mk("d", "d", 1'b0, 1'b1, 1'b0);
        s[4][0] = lit("a");
        s[4][1] = lit("b");
        s[4][2] = lit("a");
        return s;
    endfunction

endpackage

// File: rtl/nfa_elem.sv
module nfa_elem
    import nfa_pkg::*;
#(
    parameter elem_t CFG     = '0,
    parameter bit    FIRST   = 1'b0,
    parameter bit    OPT_END = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vld,
    input  logic       sop,
    input  logic [7:0] byte_in,
    input  logic       prev_st,
    input  logic       skip_now,
    output logic       now_o,
    output logic       st_o
);
    logic enable, cmp, hit;

    assign enable = FIRST ? 1'b1 : (prev_st & ~sop);
    assign cmp    = CFG.wild | (byte_in == CFG.chr) | (byte_in == CFG.alt);
    assign hit    = CFG.used & enable & cmp;
    assign now_o  = hit | (OPT_END & skip_now);

    always_ff @(posedge clk) begin
        if (rst)      st_o <= 1'b0;
        else if (vld) st_o <= now_o;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(st_o));

    p_adv_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(st_o) |-> $past(vld));

    if (!FIRST && !OPT_END) begin : g_sop_chk
        p_sop_r9: assert property (@(posedge clk) disable iff (rst)
            (vld && sop) |=> !st_o);
    end
endmodule

// File: rtl/nfa_chain.sv
module nfa_chain
    import nfa_pkg::*;
#(
    parameter pat_row_t ROW = '0,
    parameter int       LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vld,
    input  logic       sop,
    input  logic [7:0] byte_in,
    output logic       done
);
    localparam int PLEN = (row_len(ROW) < LEN) ? row_len(ROW) : LEN;

    for (genvar j = 0; j < LEN; j++) begin : g_pos
        localparam bit OEND = opt_end(ROW, j);
        localparam int HEAD = grp_head(ROW, j);
        logic prev_w, skip_w, now_w, st_w;

        if (j == 0) begin : g_first
            assign prev_w = 1'b1;
        end else begin : g_next
            assign prev_w = g_pos[j-1].st_w;
        end

        if (OEND && HEAD > 0) begin : g_skip
            assign skip_w = g_pos[HEAD-1].now_w;
        end else begin : g_noskip
            assign skip_w = 1'b0;
        end

        nfa_elem #(
            .CFG     (ROW[j]),
            .FIRST   (j == 0),
            .OPT_END (OEND && HEAD > 0)
        ) i_elem (
            .clk      (clk),
            .rst      (rst),
            .vld      (vld),
            .sop      (sop),
            .byte_in  (byte_in),
            .prev_st  (prev_w),
            .skip_now (skip_w),
            .now_o    (now_w),
            .st_o     (st_w)
        );
    end

    if (PLEN > 0) begin : g_done
        assign done = g_pos[PLEN-1].now_w;
    end else begin : g_empty
        assign done = 1'b0;
    end
endmodule

// File: rtl/nfa_matcher.sv
module nfa_matcher
    import nfa_pkg::*;
#(
    parameter int       NUM_PATS = 5,
    parameter int       PAT_LEN  = 4,
    parameter pat_set_t PATTERNS = default_set()
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_sop,
    input  logic [7:0]          in_byte,
    output logic                hit_any,
    output logic [NUM_PATS-1:0] hit_vec
);
    logic [NUM_PATS-1:0] done;

    for (genvar p = 0; p < NUM_PATS; p++) begin : g_pat
        nfa_chain #(
            .ROW (PATTERNS[p]),
            .LEN (PAT_LEN)
        ) i_chain (
            .clk     (clk),
            .rst     (rst),
            .vld     (in_valid),
            .sop     (in_sop),
            .byte_in (in_byte),
            .done    (done[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_vec <= '0;
            hit_any <= 1'b0;
        end else begin
            hit_vec <= in_valid ? done : '0;
            hit_any <= in_valid & (|done);
        end
    end

    p_any_or_r11: assert property (@(posedge clk) disable iff (rst)
        hit_any == (|hit_vec));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (hit_vec == '0));

    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        hit_any |-> $past(in_valid));

    initial begin
        assert (NUM_PATS >= 1 && NUM_PATS <= MAX_PATS);
        assert (PAT_LEN >= 1 && PAT_LEN <= MAX_LEN);
    end
endmodule

// File: tb/test_nfa_matcher.sv
module test_nfa_matcher;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          hit_any;
    logic [NP-1:0] hit_vec;

    int     n_chk = 0;
    int     n_bad = 0;
    logic [7:0] hist [16];
    int     hn = 0;

    always #10 clk = ~clk;

    nfa_matcher i_nfa_matcher (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_byte  (in_byte),
        .hit_any  (hit_any),
        .hit_vec  (hit_vec)
    );

    // '?' in a model string stands for any byte.
    function automatic bit ends(string s);
        if (s.len() > hn) return 1'b0;
        for (int k = 0; k < s.len(); k++) begin
            if (s[s.len()-1-k] != "?" && s[s.len()-1-k] != hist[k]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [NP-1:0] model();
        logic [NP-1:0] m;
        m[0] = ends("a") | ends("ab") | ends("ac");
        m[1] = ends("GT") | ends("GET");
        m[2] = ends("x?z");
        m[3] = ends("ab") | ends("abcd");
        m[4] = ends("aba");
        return m;
    endfunction

    task automatic check(string tag, logic [NP-1:0] ev);
        n_chk++;
        if (hit_vec !== ev || hit_any !== (|ev)) begin
            n_bad++;
            $display("FAIL %s: hit_vec=%b hit_any=%b expected %b/%b",
                     tag, hit_vec, hit_any, ev, |ev);
        end
    endtask

    task automatic step(bit v, bit s, logic [7:0] b, string tag);
        logic [NP-1:0] ev;
        @(negedge clk);
        in_valid = v; in_sop = s; in_byte = b;
        ev = '0;
        if (v) begin
            if (s) hn = 0;
            for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = b;
            if (hn < 16) hn++;
            ev = model();
        end
        @(posedge clk);
        #1;
        check(tag, ev);
    endtask

    task automatic feed(string str, string tag);
        for (int i = 0; i < str.len(); i++) step(1'b1, 1'b0, str[i], tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        hn = 0;
    endtask

    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        #1;
        check("R1 reset state", '0);
        feed("GE", "R1 prefix");
        do_reset();
        step(1'b1, 1'b0, "T", "R1 no carry over reset");

        feed("qqGET", "R2 R5 literal chain at offset");
        feed("x#z", "R3 wildcard");
        step(1'b1, 1'b0, "x", "R3 wildcard");
        step(1'b1, 1'b0, 8'hFF, "R3 wildcard byte FF");
        step(1'b1, 1'b0, "z", "R3 wildcard end");
        feed("qaqacqGTq", "R4 optional skip and take");
        feed("abcq", "R4 abc no full group");
        feed("abcd", "R4 full group");
        feed("ababa", "R6 R7 overlap and simultaneous");
        step(1'b0, 1'b0, 8'h00, "R10 pulse ends");
        step(1'b1, 1'b0, "G", "R8 gap start");
        step(1'b0, 1'b0, "T", "R8 idle byte ignored");
        step(1'b0, 1'b1, "q", "R8 idle sop ignored");
        step(1'b1, 1'b0, "T", "R8 gap completes");
        step(1'b1, 1'b0, "G", "R9 pending");
        step(1'b1, 1'b1, "T", "R9 sop discards");
        step(1'b1, 1'b1, "a", "R9 sop byte starts match");
        step(1'b1, 1'b0, "b", "R9 R7 after sop");

        begin
            string alpha = "abcdGETxzq?";
            for (int n = 0; n < 3000; n++) begin
                bit v = ($urandom_range(0, 9) < 8);
                bit s = ($urandom_range(0, 19) == 0);
                logic [7:0] b = ($urandom_range(0, 15) == 0) ? 8'($urandom())
                              : alpha[$urandom_range(0, alpha.len()-1)];
                step(v, s, b, "R5 R6 R7 R11 random");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule